// File: doc/BRIEF.md
# Slot Hot-Plug Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches them through a small register port with byte enables. The slot side reports device insertion, removal, boot-time presence and attention-button presses. A write that touches slot control is handled as one command. Every such command raises a command-completed event. A control bit toggles the electromechanical interlock state.

From the event status bits and their enables, the block derives one notification condition. Each time that condition changes value, the block signals software once. It uses a one-cycle MSI-X request when MSI-X is enabled, otherwise a one-cycle MSI request when MSI is enabled, otherwise a level INTx output. Both message requests carry a 5-bit interrupt message number held in a programmable register. Message formation, power control and link handling live elsewhere.

Top module: `slot_hp_ctrl`

## Requirements
- R1: The notification condition is true exactly when hot-plug interrupt enable (control bit 5) is set and at least one event status bit (status bit 0 button, bit 3 presence changed, bit 4 command completed) is set together with the control enable at the same bit position.
- R2: A notification is issued only in the cycle after the condition changes value; setting an event status bit that is already 1 produces none.
- R3: A notification becomes a one-cycle `msix_req` when `msix_en` is 1, else a one-cycle `msi_req` when `msi_en` is 1. `irq_vec` carries the message number written to bits 4:0 at address 2.
- R4: With both message modes disabled, `intx_out` follows the condition on each change, and a status write that leaves the condition false deasserts it.
- R5: Status bits 0, 3 and 4 (address 1) are cleared by writing 1 in an enabled byte; writing 0, or writing to other status bits, leaves them unchanged.
- R6: Any write to address 0 with a nonzero byte enable is one command. It updates the writable control bits (0, 3, 4, 5, indicator fields 7:6 and 9:8, and bit 11) in the enabled bytes, then sets command-completed.
- R7: Writing 1 to control bit 11 toggles interlock status (status bit 7), and bit 11 always reads 0.
- R8: Insertion sets presence state (status bit 6) and presence-changed. Removal clears presence state and sets presence-changed. Boot-time presence sets presence state with no presence-changed.
- R9: While interlock status is 1, an insertion or removal request is refused: `slot_busy` pulses in the following cycle and the status register does not change.
- R10: Reset clears all enables, the interlock control, the interlock status and all event status bits. Both indicator fields are set to the off code 2'b11, so control reads 0x03C0, and `intx_out` is low.

Top module ports and widths below use the default `VEC_W` of 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 message number |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| slot_insert | input | 1 | Device insertion request (one cycle) |
| slot_remove | input | 1 | Device removal request (one cycle) |
| slot_boot_present | input | 1 | Device present at power-up (one cycle) |
| slot_button | input | 1 | Attention button press (one cycle) |
| slot_busy | output | 1 | Insertion/removal refused due to interlock |
| msix_en | input | 1 | MSI-X signalling enabled |
| msi_en | input | 1 | MSI signalling enabled |
| msix_req | output | 1 | One-cycle MSI-X notification request |
| msi_req | output | 1 | One-cycle MSI notification request |
| irq_vec | output | 5 | Interrupt message number for the request |
| intx_out | output | 1 | Level interrupt when both message modes are off |

## Verification
The embedded properties assume single-cycle slot requests and a clean reset at time zero. They also assume that boot-time presence never arrives in the same cycle as an insertion refused by the interlock. The stimulus drives every slot input for exactly one cycle, with several idle cycles between operations, and never overlaps two slot events. Signalling modes are switched only while the bench model knows the interrupt level is already settled. The scoreboard therefore sees a single expected message per condition change.

// File: rtl/slot_hp_pkg.sv
// Shared constants for the slot hot-plug controller.
// Bit positions follow the standard slot control/status layout, which
// the requirements and software depend on.
package slot_hp_pkg;
    localparam int DW      = 16;
    localparam int AW      = 2;

    // status bit positions
    localparam int S_BTN   = 0;
    localparam int S_PCHG  = 3;
    localparam int S_CDONE = 4;
    localparam int S_PRES  = 6;
    localparam int S_LOCK  = 7;

    // control bit positions
    localparam int C_HPIE  = 5;
    localparam int C_LTOG  = 11;

    // event bits share positions in control (enables) and status
    localparam logic [DW-1:0] EVT_MASK  = 16'h0019;
    // writable control bits, interlock toggle included
    localparam logic [DW-1:0] CTL_WMASK = 16'h0BF9;
    // control after reset: both indicators at off code 2'b11
    localparam logic [DW-1:0] CTL_RST   = 16'h03C0;

    typedef enum logic [AW-1:0] {
        A_CTL = 2'd0,
        A_STS = 2'd1,
        A_VEC = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/slot_ctl_regs.sv
// Slot control register and interrupt message number register.
// Assumes one write per cycle; the interlock toggle bit is never stored,
// it is turned into a one-cycle pulse instead.
module slot_ctl_regs
    import slot_hp_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_vec,
    input  logic [1:0]       be,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    ctl_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             lock_tog,
    output logic             cmd_done
);
    localparam logic [DW-1:0] TOG_BIT = DW'(1) << C_LTOG;

    logic [DW-1:0] be_mask;
    logic [DW-1:0] wmask;
    logic [DW-1:0] ctl_d;

    // expand byte enables and form the stored-bit write mask
    always_comb begin
        be_mask = {{8{be[1]}}, {8{be[0]}}};
        wmask   = CTL_WMASK & be_mask & ~TOG_BIT;
        ctl_d   = (ctl_q & ~wmask) | (wdata & wmask);
    end

    // command and toggle pulses derived from the write
    assign cmd_done = wr_ctl;
    assign lock_tog = wr_ctl & be[1] & wdata[C_LTOG];

    // control register storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_RST;
        else if (wr_ctl)
            ctl_q <= ctl_d;
    end

    // message number storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (wr_vec && be[0])
            vec_q <= wdata[VEC_W-1:0];
    end
endmodule

// File: rtl/slot_sts_regs.sv
// Slot status register: event bits with write-1-to-clear, presence
// state and interlock state. Assumes slot requests are single-cycle.
// A new event in the same cycle as a clear of that bit wins.
module slot_sts_regs
    import slot_hp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sts,
    input  logic [1:0]    be,
    input  logic [DW-1:0] wdata,
    input  logic          cmd_done,
    input  logic          lock_tog,
    input  logic          ins_req,
    input  logic          rem_req,
    input  logic          boot_pres,
    input  logic          btn,
    output logic [DW-1:0] sts_q,
    output logic          busy
);
    logic btn_q, pchg_q, cdone_q, pres_q, lock_q;
    logic [DW-1:0] clr;
    logic ins_ok, rem_ok;

    // requests are refused while the interlock is engaged
    assign ins_ok = ins_req & ~lock_q;
    assign rem_ok = rem_req & ~lock_q & ~ins_req;

    // write-1-to-clear mask limited to event bits
    assign clr = wr_sts ? (wdata & {{8{be[1]}}, {8{be[0]}}} & EVT_MASK) : '0;

    // event bits: set on event, else cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btn_q   <= 1'b0;
            pchg_q  <= 1'b0;
            cdone_q <= 1'b0;
        end else begin
            btn_q   <= btn | (btn_q & ~clr[S_BTN]);
            pchg_q  <= ins_ok | rem_ok | (pchg_q & ~clr[S_PCHG]);
            cdone_q <= cmd_done | (cdone_q & ~clr[S_CDONE]);
        end
    end

    // presence and interlock state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (ins_ok || boot_pres)
                pres_q <= 1'b1;
            else if (rem_ok)
                pres_q <= 1'b0;
            lock_q <= lock_q ^ lock_tog;
        end
    end

    // refusal indication, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else
            busy <= (ins_req | rem_req) & lock_q;
    end

    // assemble the readable status word
    always_comb begin
        sts_q          = '0;
        sts_q[S_BTN]   = btn_q;
        sts_q[S_PCHG]  = pchg_q;
        sts_q[S_CDONE] = cdone_q;
        sts_q[S_PRES]  = pres_q;
        sts_q[S_LOCK]  = lock_q;
    end

    // R6
    cmd_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cdone_q);
    // R7
    lock_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tog |=> (lock_q != $past(lock_q)));
    // R9
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ins_req || rem_req) && lock_q && !boot_pres) |=> (busy && $stable(pres_q)));
    // R8
    insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !lock_q) |=> (pres_q && pchg_q));
endmodule

// File: rtl/slot_hp_notify.sv
// Notification engine: derives the enable-masked event condition,
// tracks its previous value, and on each change signals through MSI-X,
// MSI or the INTx level. Assumes the enables are stable for a cycle.
module slot_hp_notify
    import slot_hp_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    ctl_q,
    input  logic [DW-1:0]    sts_q,
    input  logic             sts_wr,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec,
    output logic             msix_req,
    output logic             msi_req,
    output logic [VEC_W-1:0] req_vec,
    output logic             intx
);
    logic cond, cond_q;

    // condition: master enable and any enabled pending event
    assign cond = ctl_q[C_HPIE] & (|(sts_q & ctl_q & EVT_MASK));

    // change tracking and routing of the notification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q   <= 1'b0;
            msix_req <= 1'b0;
            msi_req  <= 1'b0;
            req_vec  <= '0;
            intx     <= 1'b0;
        end else begin
            msix_req <= 1'b0;
            msi_req  <= 1'b0;
            if (cond != cond_q) begin
                cond_q <= cond;
                if (msix_en) begin
                    msix_req <= 1'b1;
                    req_vec  <= vec;
                end else if (msi_en) begin
                    msi_req  <= 1'b1;
                    req_vec  <= vec;
                end else begin
                    intx     <= cond;
                end
            end else if (sts_wr && !msix_en && !msi_en && !cond) begin
                intx <= 1'b0;
            end
        end
    end

    // R3
    msix_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msix_req |-> $past(msix_en));
    // R3
    msi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> ($past(msi_en) && !$past(msix_en)));
    // R2
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msix_req || msi_req) |-> (cond_q != $past(cond_q)));
    // R4
    intx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(intx) |-> (!$past(msix_en) && !$past(msi_en)));
endmodule

// File: rtl/slot_hp_ctrl.sv
// Top of the slot hot-plug controller: decodes the register port,
// multiplexes read data and connects the control, status and
// notification pieces. Assumes at most one register write per cycle.
module slot_hp_ctrl
    import slot_hp_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [1:0]       reg_be,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             slot_insert,
    input  logic             slot_remove,
    input  logic             slot_boot_present,
    input  logic             slot_button,
    output logic             slot_busy,
    input  logic             msix_en,
    input  logic             msi_en,
    output logic             msix_req,
    output logic             msi_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             intx_out
);
    logic wr_ctl, wr_sts, wr_vec;
    logic [DW-1:0] ctl_q, sts_q;
    logic [VEC_W-1:0] vec_q;
    logic lock_tog, cmd_done;

    // write decode: a write with no byte enabled is not a command
    assign wr_ctl = reg_wr && (|reg_be) && (reg_addr == A_CTL);
    assign wr_sts = reg_wr && (|reg_be) && (reg_addr == A_STS);
    assign wr_vec = reg_wr && (|reg_be) && (reg_addr == A_VEC);

    // read multiplexer
    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = ctl_q;
            A_STS:   reg_rdata = sts_q;
            A_VEC:   reg_rdata = {{(DW-VEC_W){1'b0}}, vec_q};
            default: reg_rdata = '0;
        endcase
    end

    slot_ctl_regs #(.VEC_W(VEC_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_ctl),
        .wr_vec   (wr_vec),
        .be       (reg_be),
        .wdata    (reg_wdata),
        .ctl_q    (ctl_q),
        .vec_q    (vec_q),
        .lock_tog (lock_tog),
        .cmd_done (cmd_done)
    );

    slot_sts_regs u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sts    (wr_sts),
        .be        (reg_be),
        .wdata     (reg_wdata),
        .cmd_done  (cmd_done),
        .lock_tog  (lock_tog),
        .ins_req   (slot_insert),
        .rem_req   (slot_remove),
        .boot_pres (slot_boot_present),
        .btn       (slot_button),
        .sts_q     (sts_q),
        .busy      (slot_busy)
    );

    slot_hp_notify #(.VEC_W(VEC_W)) u_ntf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_q    (ctl_q),
        .sts_q    (sts_q),
        .sts_wr   (wr_sts),
        .msix_en  (msix_en),
        .msi_en   (msi_en),
        .vec      (vec_q),
        .msix_req (msix_req),
        .msi_req  (msi_req),
        .req_vec  (irq_vec),
        .intx     (intx_out)
    );

    // R7
    toggle_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTL) |-> !reg_rdata[C_LTOG]);
endmodule

// File: tb/slot_hp_ctrl_tb.sv
module slot_hp_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [1:0] reg_be = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic slot_insert = 1'b0, slot_remove = 1'b0;
    logic slot_boot_present = 1'b0, slot_button = 1'b0;
    logic slot_busy;
    logic msix_en = 1'b0, msi_en = 1'b0;
    logic msix_req, msi_req, intx_out;
    logic [4:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // scoreboard: {is_msix, vector}
    logic [5:0] exp_q[$];

    // bench model of the register state
    logic [15:0] m_ctl;
    logic m_btn, m_pchg, m_cdone, m_pres, m_lock, m_cond, m_intx;
    logic [4:0] m_vec;

    always #5 clk = ~clk;

    slot_hp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_insert(slot_insert), .slot_remove(slot_remove),
        .slot_boot_present(slot_boot_present), .slot_button(slot_button),
        .slot_busy(slot_busy), .msix_en(msix_en), .msi_en(msi_en),
        .msix_req(msix_req), .msi_req(msi_req), .irq_vec(irq_vec),
        .intx_out(intx_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_sts();
        logic [15:0] s = '0;
        s[0] = m_btn; s[3] = m_pchg; s[4] = m_cdone; s[6] = m_pres; s[7] = m_lock;
        return s;
    endfunction

    task automatic m_reset();
        m_ctl = 16'h03C0;
        {m_btn, m_pchg, m_cdone, m_pres, m_lock, m_cond, m_intx} = '0;
        m_vec = '0;
    endtask

    // R1 condition model; pushes the expected notification on change
    task automatic m_eval(input bit sts_write);
        logic c;
        c = m_ctl[5] & ((m_btn & m_ctl[0]) | (m_pchg & m_ctl[3]) | (m_cdone & m_ctl[4]));
        if (c != m_cond) begin
            m_cond = c;
            if (msix_en) exp_q.push_back({1'b1, m_vec});
            else if (msi_en) exp_q.push_back({1'b0, m_vec});
            else m_intx = c;
        end else if (sts_write && !msix_en && !msi_en && !c) begin
            m_intx = 1'b0;
        end
    endtask

    // monitor: pops the scoreboard on each message request
    always @(negedge clk) begin
        if (rst_n && (msix_req || msi_req)) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected request", {msix_req, msi_req}, 16'h0);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                check("R3 request kind/vector", {10'd0, msix_req, irq_vec}, {10'd0, e});
                check("R3 single request", {15'd0, msix_req & msi_req}, 16'h0);
            end
        end
    end

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] bm, wm;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        bm = {{8{be[1]}}, {8{be[0]}}};
        if (a == 2'd0) begin
            wm = 16'h03F9 & bm;
            m_ctl = (m_ctl & ~wm) | (d & wm);
            if (be[1] && d[11]) m_lock = ~m_lock;
            m_cdone = 1'b1;
            m_eval(1'b0);
        end else if (a == 2'd1) begin
            if (bm[0] && d[0]) m_btn = 1'b0;
            if (bm[3] && d[3]) m_pchg = 1'b0;
            if (bm[4] && d[4]) m_cdone = 1'b0;
            m_eval(1'b1);
        end else if (be[0]) begin
            m_vec = d[4:0];
        end
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'd0;
        settle();
    endtask

    task automatic check_regs(input string req);
        reg_addr = 2'd0; #1; check({req, " ctl"}, reg_rdata, m_ctl);
        reg_addr = 2'd1; #1; check({req, " sts"}, reg_rdata, m_sts());
        reg_addr = 2'd2; #1; check({req, " vec"}, reg_rdata, {11'd0, m_vec});
        check({req, " intx"}, {15'd0, intx_out}, {15'd0, m_intx});
    endtask

    task automatic slot_op(input int kind);
        @(negedge clk);
        case (kind)
            0: slot_insert = 1'b1;
            1: slot_remove = 1'b1;
            2: slot_boot_present = 1'b1;
            default: slot_button = 1'b1;
        endcase
        if (kind == 3) m_btn = 1'b1;
        else if (kind == 2) m_pres = 1'b1;
        else if (!m_lock) begin
            m_pres = (kind == 0);
            m_pchg = 1'b1;
        end
        m_eval(1'b0);
        @(negedge clk);
        if (kind < 2) check("R9 busy", {15'd0, slot_busy}, {15'd0, m_lock});
        {slot_insert, slot_remove, slot_boot_present, slot_button} = '0;
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        settle();
    endtask

    initial begin
        m_reset();
        do_reset();
        check_regs("R10 reset");

        wr(2'd2, 16'h0005, 2'b01);
        msix_en = 1'b1;
        wr(2'd0, 16'h03E1, 2'b11);          // R6 HPIE+button enable, CC set
        check_regs("R6 command");
        slot_op(3);                          // R1 button -> MSI-X
        slot_op(3);                          // R2 already set, nothing new
        check_regs("R2 repeat");
        wr(2'd1, 16'h0001, 2'b01);           // R5 clear button -> change
        check_regs("R5 w1c");
        wr(2'd1, 16'h0010, 2'b10);           // R5 wrong byte: no effect
        check_regs("R5 byte enable");

        msix_en = 1'b0; msi_en = 1'b1;
        wr(2'd2, 16'h0013, 2'b01);
        wr(2'd0, 16'h03E9, 2'b01);           // presence enable
        slot_op(0);                          // R8 insert -> MSI
        check_regs("R8 insert");
        wr(2'd0, 16'h0800, 2'b10);           // R7 engage interlock
        check_regs("R7 engaged");
        slot_op(1);                          // R9 refused
        check_regs("R9 refused");
        wr(2'd0, 16'h0800, 2'b10);           // R7 release
        check_regs("R7 released");

        msi_en = 1'b0;
        wr(2'd1, 16'h0019, 2'b01);
        check_regs("R4 cleared");
        wr(2'd0, 16'h03F9, 2'b01);           // R4 CC enabled -> intx high
        check_regs("R4 assert");
        wr(2'd1, 16'h0010, 2'b01);
        check_regs("R4 deassert");
        slot_op(1);                          // R8 removal -> intx
        check_regs("R8 remove");
        do_reset();
        check_regs("R10 mid-run reset");
        slot_op(2);                          // R8 boot presence, no event
        check_regs("R8 boot");

        msix_en = 1'b1; msi_en = 1'b1;
        wr(2'd0, 16'h03F0, 2'b01);           // R3 both enabled -> MSI-X
        check_regs("R3 priority");
        check("R2 scoreboard drained", 16'(exp_q.size()), 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule